// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block turns a 24-bit bus address into one of four chip-select lines. Each select is set up with three things: a 2-bit memory type, a 4-bit window-size code and a base value. A select claims an access when the address bits above its window size equal the matching bits of its base. The block also reports the memory type of the winning select, so later logic can send the access to an SRAM engine or an SDRAM engine.

The configuration is checked as the decode runs. A base with stray bits below the window boundary is an error. An SDRAM type on any select other than the last one is also an error. A select with an error raises its error flag and never claims an access. When windows overlap, the lowest-numbered select that matches wins. All outputs are registered, and each shows the inputs from the clock edge before.

Top module: `cs_window_decoder`

## Requirements
- R1: While reset is high and on the first clock after it, `cs_o`, `hit_o`, `mtype_o` and `cfg_err_o` are all zero. After that, every output shows the inputs sampled at the previous rising edge.
- R2: The type field of select i is `mode_i[2i+1:2i]`, coded as 00 off, 01 SRAM, 10 low-pin-count SRAM and 11 SDRAM. A select of type 00 never asserts and never flags an error, whatever its base or size.
- R3: Size code c (`size_i[4i+3:4i]`) gives a window of 2^(9+c) bytes. Bit k of the 15-bit base (`base_i[15i+14:15i]`) stands for address bit 9+k. The select matches when address bits 9+c..23 equal base bits c..14.
- R4: Size code 15 is a 16 MB window. It compares no address bits and matches every address.
- R5: An enabled select whose base has any bit below position c set raises `cfg_err_o[i]` and never asserts.
- R6: An 8 MB window (code 14) matches only when it sits at address 0x000000 or 0x800000. Any other base is an error under R5.
- R7: Type 11 (SDRAM) is legal only on select 3. On selects 0 to 2 it raises that select's error flag and the select never asserts.
- R8: When several valid selects match, only the lowest-numbered one asserts. `cs_o` is always one-hot or zero.
- R9: `mtype_o` carries the type code of the asserted select, and `hit_o` is high exactly when a select asserts. With no select asserted, both are zero.
- R10: When `req_i` is low, no select asserts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Address is valid this cycle |
| addr_i | input | 24 | Bus byte address |
| mode_i | input | 8 | Memory type per select, 2 bits each |
| size_i | input | 16 | Window-size code per select, 4 bits each |
| base_i | input | 60 | Base per select, 15 bits each, holding address bits 9..23 |
| cs_o | output | 4 | Registered chip selects, one-hot or zero |
| hit_o | output | 1 | A select asserted |
| mtype_o | output | 2 | Type code of the asserted select |
| cfg_err_o | output | 4 | Per-select configuration error |

## Verification
The hardest case to reach from the ports is a select that would match but is blocked by its own bad setup while a later select also matches. Only then does the priority logic show whether an error removes a select from arbitration or just hides it. The bench builds this on purpose in three steps. It places a misaligned window or an illegal SDRAM type on a low select. It puts a 16 MB catch-all window on a higher select. It then checks that the access passes to the higher select and that the blocked select's error flag is set.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;

    typedef enum logic [1:0] {
        CS_OFF   = 2'b00,
        CS_SRAM  = 2'b01,
        CS_LPC   = 2'b10,
        CS_SDRAM = 2'b11
    } cs_mode_e;

    typedef struct packed {
        logic match;
        logic err;
    } win_res_t;

endpackage

// File: rtl/cs_window.sv
module cs_window
    import cs_decode_pkg::*;
#(
    parameter int BASE_W   = 15,
    parameter int SIZE_W   = 4,
    parameter bit SDRAM_OK = 1'b0
) (
    input  cs_mode_e            mode,
    input  logic [SIZE_W-1:0]   size,
    input  logic [BASE_W-1:0]   base,
    input  logic [BASE_W-1:0]   addr_hi,
    output win_res_t            res
);

    logic [BASE_W-1:0] keep;
    logic              enabled;
    logic              misalign;
    logic              bad_type;

    always_comb begin
        for (int k = 0; k < BASE_W; k++) begin
            keep[k] = (k >= int'(size));
        end
    end

    assign enabled  = (mode != CS_OFF);
    assign misalign = |(base & ~keep);
    assign bad_type = (mode == CS_SDRAM) && !SDRAM_OK;

    always_comb begin
        res.err   = enabled && (misalign || bad_type);
        res.match = enabled && !res.err && (((addr_hi ^ base) & keep) == '0);
    end

    // R2: an off select neither matches nor flags
    always_comb begin
        if (mode == CS_OFF) begin
            a_r2_off_silent: assert (!res.match && !res.err);
        end
    end

endmodule

// File: rtl/cs_priority.sv
module cs_priority #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // R8: at most one grant and only to a requester
    always_comb begin
        a_r8_grant_onehot: assert ($onehot0(grant));
        a_r8_grant_subset: assert ((grant & ~req) == '0);
    end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cs_decode_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int ADDR_W    = 24,
    parameter int MIN_SHIFT = 9,
    parameter int SIZE_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [2*NUM_CS-1:0]         mode_i,
    input  logic [SIZE_W*NUM_CS-1:0]    size_i,
    input  logic [(ADDR_W-MIN_SHIFT)*NUM_CS-1:0] base_i,
    output logic [NUM_CS-1:0]           cs_o,
    output logic                        hit_o,
    output logic [1:0]                  mtype_o,
    output logic [NUM_CS-1:0]           cfg_err_o
);

    localparam int BASE_W = ADDR_W - MIN_SHIFT;

    logic [BASE_W-1:0] addr_hi;
    win_res_t          res   [NUM_CS];
    cs_mode_e          modes [NUM_CS];
    logic [NUM_CS-1:0] match_v;
    logic [NUM_CS-1:0] err_v;
    logic [NUM_CS-1:0] grant;
    cs_mode_e          win_mode;

    assign addr_hi = addr_i[ADDR_W-1:MIN_SHIFT];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        assign modes[g] = cs_mode_e'(mode_i[2*g +: 2]);

        cs_window #(
            .BASE_W   (BASE_W),
            .SIZE_W   (SIZE_W),
            .SDRAM_OK (g == NUM_CS-1)
        ) i_win (
            .mode    (modes[g]),
            .size    (size_i[SIZE_W*g +: SIZE_W]),
            .base    (base_i[BASE_W*g +: BASE_W]),
            .addr_hi (addr_hi),
            .res     (res[g])
        );

        assign match_v[g] = res[g].match && req_i;
        assign err_v[g]   = res[g].err;
    end

    cs_priority #(.N(NUM_CS)) i_prio (
        .req   (match_v),
        .grant (grant)
    );

    always_comb begin
        win_mode = CS_OFF;
        for (int i = 0; i < NUM_CS; i++) begin
            if (grant[i]) win_mode = modes[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_o      <= '0;
            hit_o     <= 1'b0;
            mtype_o   <= 2'b00;
            cfg_err_o <= '0;
        end else begin
            cs_o      <= grant;
            hit_o     <= |grant;
            mtype_o   <= win_mode;
            cfg_err_o <= err_v;
        end
    end

    // R8: registered selects stay one-hot or zero
    a_r8_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_o));

    // R10: no request, no select next cycle
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (cs_o == '0));

    // R9: an asserted select always reports a type and a hit
    a_r9_type_hit: assert property (@(posedge clk) disable iff (rst)
        (cs_o != '0) |-> (hit_o && mtype_o != 2'b00));

    // R7: an SDRAM type only ever comes out of the last select
    a_r7_sdram_last: assert property (@(posedge clk) disable iff (rst)
        (mtype_o == 2'b11) |-> cs_o[NUM_CS-1]);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
        // R5: a flagged select never asserts
        a_r5_err_blocks: assert property (@(posedge clk) disable iff (rst)
            cfg_err_o[g] |-> !cs_o[g]);
    end

endmodule

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [23:0] addr_i;
    logic [7:0]  mode_i;
    logic [15:0] size_i;
    logic [59:0] base_i;
    logic [3:0]  cs_o;
    logic        hit_o;
    logic [1:0]  mtype_o;
    logic [3:0]  cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cs_window_decoder i_cs_window_decoder (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i),
        .mode_i(mode_i), .size_i(size_i), .base_i(base_i),
        .cs_o(cs_o), .hit_o(hit_o), .mtype_o(mtype_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(string tag, logic [3:0] exp_cs, logic [1:0] exp_t,
                         logic [3:0] exp_err);
        logic exp_hit;
        exp_hit = (exp_cs != 0);
        checks++;
        if (cs_o !== exp_cs || hit_o !== exp_hit || mtype_o !== exp_t ||
            cfg_err_o !== exp_err) begin
            errors++;
            $display("FAIL %s: cs=%b hit=%b type=%b err=%b expected cs=%b hit=%b type=%b err=%b",
                     tag, cs_o, hit_o, mtype_o, cfg_err_o, exp_cs, exp_hit, exp_t, exp_err);
        end
    endtask

    task automatic set_cs(int idx, logic [1:0] m, logic [3:0] sz, logic [14:0] b);
        mode_i[2*idx +: 2]   = m;
        size_i[4*idx +: 4]   = sz;
        base_i[15*idx +: 15] = b;
    endtask

    task automatic clear_cfg();
        @(negedge clk);
        mode_i = '0; size_i = '0; base_i = '0;
    endtask

    task automatic access(logic r, logic [23:0] a);
        @(negedge clk);
        req_i  = r;
        addr_i = a;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_i = 1'b1; addr_i = '0;
        mode_i = 8'hFF; size_i = '0; base_i = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset", 4'b0000, 2'b00, 4'b0000);
        mode_i = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset, all off", 4'b0000, 2'b00, 4'b0000);
    endtask

    task automatic t_sram_window();
        clear_cfg();
        set_cs(0, 2'b01, 4'd0, 15'h0800);        // 512 B at 0x100000
        access(1'b1, 24'h1001FF);
        check("R3 SRAM 512B top byte", 4'b0001, 2'b01, 4'b0000);
        access(1'b1, 24'h100200);
        check("R3 SRAM 512B just above", 4'b0000, 2'b00, 4'b0000);
        access(1'b1, 24'h0FFFFF);
        check("R3 SRAM 512B just below", 4'b0000, 2'b00, 4'b0000);
    endtask

    task automatic t_lpc_window();
        clear_cfg();
        set_cs(2, 2'b10, 4'd2, 15'h0010);        // 2 KB at 0x002000
        access(1'b1, 24'h0027FF);
        check("R3 LPC 2KB top", 4'b0100, 2'b10, 4'b0000);
        access(1'b1, 24'h002800);
        check("R3 LPC 2KB above", 4'b0000, 2'b00, 4'b0000);
    endtask

    task automatic t_full_and_priority();
        clear_cfg();
        set_cs(1, 2'b01, 4'd15, 15'h0000);       // 16 MB catch-all
        access(1'b1, 24'hABCDEF);
        check("R4 16MB matches anything", 4'b0010, 2'b01, 4'b0000);
        set_cs(0, 2'b10, 4'd0, 15'h0800);
        access(1'b1, 24'h100010);
        check("R8 overlap lowest wins", 4'b0001, 2'b10, 4'b0000);
        access(1'b1, 24'hFFFFFF);
        check("R8 fall through to select 1", 4'b0010, 2'b01, 4'b0000);
    endtask

    task automatic t_disabled();
        clear_cfg();
        set_cs(0, 2'b00, 4'd4, 15'h0801);        // off, junk base
        set_cs(2, 2'b01, 4'd15, 15'h0000);
        access(1'b1, 24'h100000);
        check("R2 off select ignored, no error", 4'b0100, 2'b01, 4'b0000);
    endtask

    task automatic t_misalign();
        clear_cfg();
        set_cs(0, 2'b01, 4'd4, 15'h0801);        // 8 KB, low bits set
        set_cs(3, 2'b01, 4'd15, 15'h0000);
        access(1'b1, 24'h100200);
        check("R5 misaligned blocked, passes on", 4'b1000, 2'b01, 4'b0001);
    endtask

    task automatic t_sdram_place();
        clear_cfg();
        set_cs(1, 2'b11, 4'd15, 15'h0000);       // SDRAM on select 1
        set_cs(3, 2'b01, 4'd15, 15'h0000);
        access(1'b1, 24'h000100);
        check("R7 SDRAM on select 1 rejected", 4'b1000, 2'b01, 4'b0010);
        set_cs(1, 2'b00, 4'd0, 15'h0000);
        set_cs(3, 2'b11, 4'd15, 15'h0000);
        access(1'b1, 24'h000100);
        check("R7 R9 SDRAM on select 3", 4'b1000, 2'b11, 4'b0000);
    endtask

    task automatic t_eight_meg();
        clear_cfg();
        set_cs(3, 2'b11, 4'd14, 15'h4000);       // 8 MB at 0x800000
        access(1'b1, 24'h800000);
        check("R6 8MB upper half low edge", 4'b1000, 2'b11, 4'b0000);
        access(1'b1, 24'h7FFFFF);
        check("R6 8MB below base", 4'b0000, 2'b00, 4'b0000);
        set_cs(3, 2'b11, 4'd14, 15'h0000);
        access(1'b1, 24'h7FFFFF);
        check("R6 8MB at zero", 4'b1000, 2'b11, 4'b0000);
        set_cs(3, 2'b11, 4'd14, 15'h2000);       // 0x400000 not allowed
        access(1'b1, 24'h400000);
        check("R6 8MB at 0x400000 is error", 4'b0000, 2'b00, 4'b1000);
    endtask

    task automatic t_no_request();
        clear_cfg();
        set_cs(0, 2'b01, 4'd15, 15'h0000);
        access(1'b0, 24'h123456);
        check("R10 idle bus", 4'b0000, 2'b00, 4'b0000);
        access(1'b1, 24'h123456);
        check("R10 request again", 4'b0001, 2'b01, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_sram_window();
        t_lpc_window();
        t_full_and_priority();
        t_disabled();
        t_misalign();
        t_sdram_place();
        t_eight_meg();
        t_no_request();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule